// File: doc/BRIEF.md
# Multihit Common-Stop Time Digitizer

This block timestamps both edges of pulses on several digital input channels and reports them relative to a later trigger. Each channel keeps a short ring of its most recent edges. An edge ages by one count for every clock in which the pipeline runs, and one count is one sampling clock period. The default configuration is 0.5 ns per count and a 64000-count look-back, which covers 32 us. The ages stop counting at one past the look-back limit.

When a trigger is accepted, the pipeline stops. A sequencer walks the channels in ascending order. Within each channel it copies every edge that lies inside the look-back window into a free event slot, oldest edge first. It then closes the slot with an end-of-event word that carries the number of hits in the event. The store holds several events. A sequential read port drains them one word per clock, and no trigger is taken while every slot is occupied.

A typical system feeds discriminated detector pulses into `hit_in`, raises `trig` from the trigger logic, and reads the buffered events through `rd_en`.

Top module: `mhtdc_top`

## Requirements
- R1: Each change of level on a channel, sampled while the pipeline runs, becomes one hit. The edge bit is 1 for a low-to-high change and 0 for high-to-low.
- R2: A hit's time field counts the running clock edges from the edge that sampled the input change up to the edge that sampled the accepted trigger. An input change sampled one edge before the trigger reads 1. Edges at which the pipeline was stopped are not counted.
- R3: A hit is reported only if its time is at most WIN. Older edges are omitted from the event.
- R4: Each channel keeps only its HD most recent edges. A newer edge overwrites the oldest one.
- R5: Event order and word layout are fixed.
  - Hits are listed by ascending channel, and within a channel oldest first.
  - A hit word is {0 at bit WW-1, channel, edge bit at bit 16, time in bits 15:0}.
  - The end-of-event word has 1 at bit WW-1, zero channel and edge fields, and the hit count in bits 15:0.
- R6: After a trigger is accepted, `busy` is high for exactly NCH plus the number of hits clock cycles. After that it falls, unless every slot is occupied. Input changes sampled on the accepting edge or during those cycles are never recorded.
- R7: At most NEV events are held, and `busy` stays high while all slots are occupied. A trigger sampled while `busy` is high is ignored: it creates no event and does not stop the pipeline.
- R8: Read timing:
  - With `rd_en` high and an event stored, one word appears per clock, with `rd_valid` high in the cycle after `rd_en` was sampled.
  - `rd_valid` is low when `rd_en` is low or nothing is stored.
  - Emitting an end-of-event word frees its slot, and `busy` is low from that word's cycle if no conversion is running.
- R9: A trigger does not clear the edge history. An edge is reported again by later triggers for as long as it stays inside the window.
- R10: After reset, `busy` and `rd_valid` are low, no event is stored and the history is empty. A first trigger with no input activity yields only an end-of-event word with count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one period is one time count |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_in | input | NCH | Discriminated channel inputs |
| trig | input | 1 | Trigger (common stop), sampled each clock |
| busy | output | 1 | High during conversion or while all event slots are full |
| rd_en | input | 1 | Read request, one word per clock |
| rd_valid | output | 1 | `rd_word` holds a word this cycle |
| rd_word | output | 2+clog2(NCH)+16 | Hit word or end-of-event word |

## Verification
Several properties are checked on every cycle:
- a conversion starts only from a trigger sampled while not busy;
- an event is never committed into a full store;
- every written hit time lies between 1 and WIN;
- no history entry is written while the converter runs;
- at most one channel is consumed per cycle;
- read data only follows a read request.

Other behaviour is shown only by the bench's scenarios: the exact time values, oldest-first ordering, ring overwrite, the window boundary, the length of the dead time, the dropping of edges during it, and the reappearance of edges in later events. The bench compares these against an arithmetic model of the edge stamps.

// File: rtl/mhtdc_pkg.sv
package mhtdc_pkg;

  // Width of the relative time field in every hit word.
  localparam int TIME_W = 16;

  typedef enum logic {
    CV_IDLE = 1'b0,
    CV_SCAN = 1'b1
  } conv_state_e;

  // An age of 0 means no edge; ages beyond the window are saturated.
  function automatic logic in_window(input int unsigned age, input int unsigned win);
    return (age != 0) && (age <= win);
  endfunction

  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/mhtdc_hist.sv
module mhtdc_hist
  import mhtdc_pkg::*;
#(
  parameter int HD  = 8,
  parameter int WIN = 64000,
  parameter int AGW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit_in,
  input  logic           freeze,
  input  logic           clr,
  input  logic           take,
  output logic           sel_ok,
  output logic           sel_rise,
  output logic [AGW-1:0] sel_age,
  output logic           edge_rec
);
  localparam int HIW = $clog2(HD);

  logic [HD-1:0]  vld_q, rise_q, tkn_q, elig;
  logic [AGW-1:0] age_q [HD];
  logic [HIW-1:0] wp_q, pick;
  logic           prev_q;

  assign edge_rec = (hit_in != prev_q) && !freeze;

  always_comb begin
    for (int i = 0; i < HD; i++) begin
      elig[i] = vld_q[i] && !tkn_q[i] && in_window(32'(age_q[i]), WIN);
    end
  end

  // Oldest eligible entry: scan from the write pointer forward.
  always_comb begin
    logic [HIW-1:0] k;
    sel_ok = 1'b0;
    pick   = '0;
    k      = '0;
    for (int l = HD - 1; l >= 0; l--) begin
      k = wp_q + HIW'(l);
      if (elig[k]) begin
        sel_ok = 1'b1;
        pick   = k;
      end
    end
  end

  assign sel_rise = rise_q[pick];
  assign sel_age  = age_q[pick];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rise_q <= '0;
      tkn_q  <= '0;
      wp_q   <= '0;
      prev_q <= 1'b0;
      for (int i = 0; i < HD; i++) age_q[i] <= '0;
    end else begin
      prev_q <= hit_in;
      if (clr) begin
        tkn_q <= '0;
      end else if (take) begin
        tkn_q[pick] <= 1'b1;
      end
      if (!freeze) begin
        for (int i = 0; i < HD; i++) begin
          if (vld_q[i] && (age_q[i] <= AGW'(WIN))) age_q[i] <= age_q[i] + 1'b1;
        end
        if (edge_rec) begin
          vld_q[wp_q]  <= 1'b1;
          rise_q[wp_q] <= hit_in;
          age_q[wp_q]  <= AGW'(1);
          wp_q         <= wp_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mhtdc_conv.sv
module mhtdc_conv
  import mhtdc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AGW = 16,
  parameter int CHW = 3,
  parameter int WW  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig,
  input  logic                    full,
  input  logic [NCH-1:0]          sel_ok,
  input  logic [NCH-1:0]          sel_rise,
  input  logic [NCH-1:0][AGW-1:0] sel_age,
  output logic                    accept,
  output logic                    conv_busy,
  output logic                    clr,
  output logic [NCH-1:0]          take_en,
  output logic                    wr_en,
  output logic [WW-1:0]           wr_word,
  output logic                    commit
);
  conv_state_e    st_q;
  logic [CHW-1:0] cch_q;
  logic           cur_ok, last_ch;

  function automatic logic [WW-1:0] hit_word(input logic [CHW-1:0] ch, input logic r,
                                             input logic [AGW-1:0] t);
    return {1'b0, ch, r, TIME_W'(t)};
  endfunction

  assign conv_busy = (st_q == CV_SCAN);
  assign accept    = trig && !conv_busy && !full;
  assign clr       = accept;
  assign cur_ok    = sel_ok[cch_q];
  assign last_ch   = (cch_q == CHW'(NCH - 1));
  assign wr_en     = conv_busy && cur_ok;
  assign take_en   = wr_en ? (NCH'(1) << cch_q) : '0;
  assign wr_word   = hit_word(cch_q, sel_rise[cch_q], sel_age[cch_q]);
  assign commit    = conv_busy && !cur_ok && last_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CV_IDLE;
      cch_q <= '0;
    end else if (accept) begin
      st_q  <= CV_SCAN;
      cch_q <= '0;
    end else if (conv_busy && !cur_ok) begin
      if (last_ch) st_q <= CV_IDLE;
      else         cch_q <= cch_q + 1'b1;
    end
  end

endmodule

// File: rtl/mhtdc_evbuf.sv
module mhtdc_evbuf
  import mhtdc_pkg::*;
#(
  parameter int NEV  = 8,
  parameter int MAXH = 64,
  parameter int CHW  = 3,
  parameter int WW   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_word,
  input  logic          commit,
  input  logic          rd_en,
  output logic          full,
  output logic          rd_valid,
  output logic [WW-1:0] rd_word
);
  localparam int PW = (NEV > 1) ? $clog2(NEV) : 1;
  localparam int CW = $clog2(NEV + 1);
  localparam int HW = $clog2(MAXH + 1);
  localparam int AW = $clog2(NEV * MAXH);

  logic [WW-1:0] mem [NEV*MAXH];
  logic [HW-1:0] cnt_q [NEV];
  logic [PW-1:0] tail_q, head_q;
  logic [CW-1:0] nev_q;
  logic [HW-1:0] wpos_q, rpos_q;
  logic [AW-1:0] waddr, raddr;
  logic          rd_fire, pop;

  function automatic logic [WW-1:0] end_word(input logic [HW-1:0] n);
    return {1'b1, {(CHW + 1){1'b0}}, TIME_W'(n)};
  endfunction

  assign waddr   = AW'(int'(tail_q) * MAXH + int'(wpos_q));
  assign raddr   = AW'(int'(head_q) * MAXH + int'(rpos_q));
  assign full    = (nev_q == CW'(NEV));
  assign rd_fire = rd_en && (nev_q != '0);
  assign pop     = rd_fire && (rpos_q == cnt_q[head_q]);

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q   <= '0;
      head_q   <= '0;
      nev_q    <= '0;
      wpos_q   <= '0;
      rpos_q   <= '0;
      rd_valid <= 1'b0;
      rd_word  <= '0;
      for (int i = 0; i < NEV; i++) cnt_q[i] <= '0;
    end else begin
      if (wr_en) wpos_q <= wpos_q + 1'b1;
      if (commit) begin
        cnt_q[tail_q] <= wpos_q;
        wpos_q        <= '0;
        tail_q        <= PW'(wrap_inc(32'(tail_q), NEV));
      end
      rd_valid <= rd_fire;
      if (rd_fire) begin
        if (pop) begin
          rd_word <= end_word(cnt_q[head_q]);
          rpos_q  <= '0;
          head_q  <= PW'(wrap_inc(32'(head_q), NEV));
        end else begin
          rd_word <= mem[raddr];
          rpos_q  <= rpos_q + 1'b1;
        end
      end
      case ({commit, pop})
        2'b10:   nev_q <= nev_q + 1'b1;
        2'b01:   nev_q <= nev_q - 1'b1;
        default: nev_q <= nev_q;
      endcase
    end
  end

endmodule

// File: rtl/mhtdc_top.sv
module mhtdc_top
  import mhtdc_pkg::*;
#(
  parameter int  NCH = 8,
  parameter int  HD  = 8,
  parameter int  WIN = 64000,
  parameter int  NEV = 8,
  localparam int CHW = $clog2(NCH),
  localparam int WW  = 2 + CHW + TIME_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit_in,
  input  logic           trig,
  output logic           busy,
  input  logic           rd_en,
  output logic           rd_valid,
  output logic [WW-1:0]  rd_word
);
  localparam int AGW  = $clog2(WIN + 2);
  localparam int MAXH = NCH * HD;

  // Named internal events, also observed by the bound checker.
  logic                    accept, conv_busy, clr, full, wr_en, commit, freeze;
  logic [NCH-1:0]          take_en, hist_wr, sel_ok, sel_rise;
  logic [NCH-1:0][AGW-1:0] sel_age;
  logic [WW-1:0]           wr_word;

  assign busy   = conv_busy || full;
  assign freeze = accept || conv_busy;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mhtdc_hist #(.HD(HD), .WIN(WIN), .AGW(AGW)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_in  (hit_in[c]),
      .freeze  (freeze),
      .clr     (clr),
      .take    (take_en[c]),
      .sel_ok  (sel_ok[c]),
      .sel_rise(sel_rise[c]),
      .sel_age (sel_age[c]),
      .edge_rec(hist_wr[c])
    );
  end

  mhtdc_conv #(.NCH(NCH), .AGW(AGW), .CHW(CHW), .WW(WW)) u_conv (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .full     (full),
    .sel_ok   (sel_ok),
    .sel_rise (sel_rise),
    .sel_age  (sel_age),
    .accept   (accept),
    .conv_busy(conv_busy),
    .clr      (clr),
    .take_en  (take_en),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .commit   (commit)
  );

  mhtdc_evbuf #(.NEV(NEV), .MAXH(MAXH), .CHW(CHW), .WW(WW)) u_evbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .commit  (commit),
    .rd_en   (rd_en),
    .full    (full),
    .rd_valid(rd_valid),
    .rd_word (rd_word)
  );

endmodule

// File: rtl/mhtdc_chk.sv
module mhtdc_chk #(
  parameter int NCH = 8,
  parameter int WIN = 64000,
  parameter int TW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trig,
  input logic           busy,
  input logic           rd_en,
  input logic           rd_valid,
  input logic           conv_busy,
  input logic           full,
  input logic           commit,
  input logic           wr_en,
  input logic [TW-1:0]  wr_time,
  input logic [NCH-1:0] take_en,
  input logic [NCH-1:0] hist_wr
);

  p_start_by_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_busy) |-> ($past(trig) && !$past(busy)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !full);

  p_time_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_time != '0) && (32'(wr_time) <= WIN)));

  p_frozen_hist_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> (hist_wr == '0));

  p_write_in_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> conv_busy);

  p_one_channel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_en));

  p_read_follows_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

endmodule

bind mhtdc_top mhtdc_chk #(.NCH(NCH), .WIN(WIN), .TW(TIME_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig),
  .busy     (busy),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .conv_busy(conv_busy),
  .full     (full),
  .commit   (commit),
  .wr_en    (wr_en),
  .wr_time  (wr_word[TIME_W-1:0]),
  .take_en  (take_en),
  .hist_wr  (hist_wr)
);

// File: tb/mhtdc_top_tb_top.sv
module mhtdc_top_tb_top;
  localparam int NCH = 4;
  localparam int HD  = 4;
  localparam int WIN = 40;
  localparam int NEV = 8;
  localparam int CHW = 2;
  localparam int TW  = 16;
  localparam int WW  = 2 + CHW + TW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] hit = '0;
  logic           trig = 1'b0;
  logic           rd_en = 1'b0;
  logic           busy, rd_valid;
  logic [WW-1:0]  rd_word;

  always #4 clk = ~clk;  // 125 MHz

  mhtdc_top #(.NCH(NCH), .HD(HD), .WIN(WIN), .NEV(NEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_in(hit), .trig(trig), .busy(busy),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_word(rd_word)
  );

  int n_chk = 0;
  int n_bad = 0;
  int live = 0;      // running (non-stopped) clock edges seen by the model
  bit mfrz = 1'b0;   // model: next clock edge is a stopped one
  int pending = 0;
  int stamp_q [NCH][$];
  bit rise_q  [NCH][$];
  logic [WW-1:0] exp_q [$];

  always @(posedge clk) if (rst_n && !mfrz) live <= live + 1;

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Flip one channel; the next clock edge samples it (R1, R4 ring model).
  task automatic toggle(input int c);
    hit[c] = ~hit[c];
    if (!mfrz) begin
      stamp_q[c].push_back(live + 1);
      rise_q[c].push_back(hit[c]);
      if (stamp_q[c].size() > HD) begin
        void'(stamp_q[c].pop_front());
        void'(rise_q[c].pop_front());
      end
    end
    @(negedge clk);
  endtask

  task automatic do_trigger(input bit noise);
    bit acc;
    int nh;
    int t;
    acc = (pending < NEV);
    trig = 1'b1;
    if (acc) mfrz = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (!acc) begin
      check(busy == 1'b1, "R7 busy while full", WW'(busy), WW'(1));
      return;
    end
    nh = 0;
    for (int c = 0; c < NCH; c++) begin
      for (int i = 0; i < stamp_q[c].size(); i++) begin
        t = live - stamp_q[c][i] + 1;  // R2 relative time
        if (t <= WIN) begin            // R3 window
          exp_q.push_back({1'b0, CHW'(c), rise_q[c][i], TW'(t)});
          nh++;
        end
      end
    end
    exp_q.push_back({1'b1, {(CHW + 1){1'b0}}, TW'(nh)});
    pending++;
    check(busy == 1'b1, "R6 busy after accept", WW'(busy), WW'(1));
    for (int k = 0; k < NCH + nh - 1; k++) begin
      if (noise) hit[NCH-1] = ~hit[NCH-1];  // R6: dropped during dead time
      @(negedge clk);
      check(busy == 1'b1, "R6 dead time", WW'(busy), WW'(1));
    end
    @(negedge clk);
    check(busy == (pending == NEV), "R6 dead time end", WW'(busy), WW'(pending == NEV));
    mfrz = 1'b0;
  endtask

  task automatic drain_event(input string req);
    logic [WW-1:0] w;
    bit was_full;
    was_full = (pending == NEV);
    rd_en = 1'b1;
    do begin
      w = exp_q.pop_front();
      @(negedge clk);
      check(rd_valid == 1'b1 && rd_word == w, req, rd_word, w);
    end while (!w[WW-1]);
    if (was_full) check(busy == 1'b0, "R8 slot freed", WW'(busy), WW'(0));
    rd_en = 1'b0;
    pending--;
    @(negedge clk);
    check(rd_valid == 1'b0, "R8 idle read port", WW'(rd_valid), WW'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    check(busy == 1'b0 && rd_valid == 1'b0, "R10 in reset", {busy, rd_valid}, '0);
    rst_n = 1'b1;
    idle(1);
    check(busy == 1'b0 && rd_valid == 1'b0, "R10 after reset", {busy, rd_valid}, '0);

    // R8: reading an empty store yields nothing
    rd_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(rd_valid == 1'b0, "R8 empty read", WW'(rd_valid), WW'(0));
    end
    rd_en = 1'b0;
    idle(1);

    // R10: empty history gives a zero-count event
    do_trigger(1'b0);
    drain_event("R10");

    // R1 R2: one pulse on channel 1
    toggle(1); idle(5); toggle(1); idle(3);
    do_trigger(1'b0);
    drain_event("R1");

    // R3: channel 0 lands at exactly WIN, channel 2 at WIN+1
    idle(WIN + 5);
    toggle(2); toggle(0); idle(WIN - 1);
    do_trigger(1'b0);
    drain_event("R3");

    // R4: six edges on channel 3, only the last HD kept
    for (int k = 0; k < 6; k++) begin toggle(3); idle(2); end
    do_trigger(1'b0);
    drain_event("R4");

    // R9: history survives the trigger
    idle(2);
    do_trigger(1'b0);
    drain_event("R9");

    // R6: channel activity during conversion is lost
    toggle(0); idle(1);
    do_trigger(1'b1);
    drain_event("R6");
    idle(2);
    do_trigger(1'b0);
    drain_event("R6");

    // R2 R5: sweep of toggle counts, spacing and trigger delay
    for (int p = 0; p < 40; p++) begin
      for (int c = 0; c < NCH; c++) begin
        for (int k = 0; k < (p + c) % 4; k++) begin
          toggle(c);
          idle((p * 3 + c * 5 + k * 7) % 11);
        end
      end
      idle((p * 13) % (WIN + 8));
      do_trigger(1'b0);
      drain_event("R5");
    end

    // R7: fill every slot, then a refused trigger
    for (int e = 0; e < NEV; e++) begin
      toggle(e % NCH); idle(2);
      do_trigger(1'b0);
    end
    toggle(1); idle(1);
    do_trigger(1'b0);
    idle(2);
    check(busy == 1'b1, "R7 still busy", WW'(busy), WW'(1));
    for (int e = 0; e < NEV; e++) drain_event("R7");
    rd_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(rd_valid == 1'b0, "R7 refused trigger left no event", WW'(rd_valid), WW'(0));
    end
    rd_en = 1'b0;
    idle(1);
    // R7: refused trigger did not stop the pipeline
    do_trigger(1'b0);
    drain_event("R7");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule